// File: doc/BRIEF.md
# Prescaled Wake-Up Timer with Dual Compare

This block is a free-running wake-up timer meant for an always-on power domain. Two single-cycle tick enables arrive on one system clock: a fast tick at 32.768 kHz and a calibrated slow tick at about 1 kHz. A source-select input picks one of them. A power-of-two prescaler then thins the chosen tick stream, and every surviving tick advances a 16-bit counter. The counter wraps from its top value back to zero.

Two compare channels watch the counter. When the counter steps onto a channel's compare value, that channel sets a sticky event flag. The flag stays set until a one is written to its clear input. A maskable interrupt output combines the enabled flags. Only channel A can request a wake-up: the wake output is channel A's flag gated by channel A's enable. With the slow tick and the largest division, one full counter period is 2^26 ms, which is roughly 67109 s.

Software sets the source, divider code, compare values and enables as plain register-style inputs. It clears flags with one-cycle write-one pulses.

Top module: `sleep_wake_timer`

## Requirements
- R1: While reset is held, and right after it, the count is 0, both flags are 0, and the wake and interrupt outputs are 0.
- R2: With source select 0, only the fast tick advances the timer. With source select 1, only the slow tick advances it. The unselected tick has no effect on the count.
- R3: With divider code N from 0 to 10, the count advances once for every 2^N selected ticks. The first advance comes on the 2^N-th tick after the prescaler was last cleared.
- R4: Divider codes 11 to 15 give the same division as code 10, that is 1024 ticks per count step.
- R5: The 16-bit count only ever increases by exactly one, and from 65535 it wraps to 0.
- R6: In a cycle where the source select or the divider code differs from its value in the previous cycle, the prescaler restarts from zero and a tick in that cycle is discarded.
- R7: Flag bit 0 (channel A) is set in the same clock edge that the count steps to compare A. Flag bit 1 (channel B) behaves the same way with compare B. Sitting on the value without a step sets nothing.
- R8: A flag stays set until its clear bit (bit 0 for A, bit 1 for B) is 1 for a cycle. A set and a clear in the same cycle leave the flag set.
- R9: The wake output is flag A AND enable bit 0. Channel B never drives the wake output.
- R10: The interrupt output is high exactly when some flag is set with its matching enable bit (bit 0 for A, bit 1 for B) high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast_i | input | 1 | One-cycle enable at 32.768 kHz |
| tick_slow_i | input | 1 | One-cycle enable from calibrated 1 kHz source |
| src_sel_i | input | 1 | Tick source: 0 fast, 1 slow |
| div_code_i | input | 4 | Prescaler code N (11 to 15 clamp to 10) |
| cmp_a_i | input | 16 | Compare value, channel A |
| cmp_b_i | input | 16 | Compare value, channel B |
| irq_en_i | input | 2 | Interrupt enables, bit 0 A, bit 1 B |
| flag_clr_i | input | 2 | Write-one clear pulses, bit 0 A, bit 1 B |
| count_o | output | 16 | Current counter value |
| flag_o | output | 2 | Sticky compare flags, bit 0 A, bit 1 B |
| irq_o | output | 1 | OR of enabled flags |
| wake_o | output | 1 | Wake request from channel A |

## Verification
The assertions assume that a flag rises only after a count step, so they read the compare value from the cycle before the rise. They also assume a flag falls only after a clear pulse and that the count moves only in a cycle that carried a tick. The checks hold as long as clear pulses and compare values come in as ordinary cycle-synchronous inputs. The stimulus changes all inputs on the falling edge only. It keeps the ticks as single-cycle levels and drives clears at a low random rate, so flags can be seen both holding and clearing.

// File: rtl/sleep_timer_pkg.sv
package sleep_timer_pkg;
    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_PRE_W  = 10;
    localparam int unsigned DEF_CODE_W = 4;
    localparam int unsigned DEF_MAXDIV = 10;
    localparam int unsigned DEF_NCMP   = 2;

    typedef struct packed {
        logic [DEF_PRE_W-1:0]  pre;
        logic                  sel;
        logic [DEF_CODE_W-1:0] code;
    } presc_state_t;
endpackage

// File: rtl/sleep_tick_prescaler.sv
module sleep_tick_prescaler
    import sleep_timer_pkg::*;
#(
    parameter int unsigned PRE_W  = DEF_PRE_W,
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned MAXDIV = DEF_MAXDIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast_i,
    input  logic              tick_slow_i,
    input  logic              src_sel_i,
    input  logic [CODE_W-1:0] div_code_i,
    output logic              step_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAXDIV);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic              sel;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t            st_d, st_q;
    logic [CODE_W-1:0] eff_code;
    logic [PRE_W:0]    mask_full;
    logic [PRE_W-1:0]  mask;
    logic              tick_sel;
    logic              cfg_change;
    logic              step_d;

    always_comb begin
        eff_code   = (div_code_i > CODE_MAX) ? CODE_MAX : div_code_i;
        mask_full  = ({{PRE_W{1'b0}}, 1'b1} << eff_code) - {{PRE_W{1'b0}}, 1'b1};
        mask       = mask_full[PRE_W-1:0];
        tick_sel   = src_sel_i ? tick_slow_i : tick_fast_i;
        cfg_change = (src_sel_i != st_q.sel) || (div_code_i != st_q.code);

        st_d      = st_q;
        st_d.sel  = src_sel_i;
        st_d.code = div_code_i;
        step_d    = 1'b0;
        if (cfg_change) begin
            st_d.pre = '0;
        end else if (tick_sel) begin
            step_d   = ((st_q.pre & mask) == mask);
            st_d.pre = st_q.pre + {{(PRE_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o = step_d;
endmodule

// File: rtl/sleep_wrap_counter.sv
module sleep_wrap_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_q_o,
    output logic [CNT_W-1:0] count_d_o
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (step_i) count_d = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_q_o = count_q;
    assign count_d_o = count_d;
endmodule

// File: rtl/sleep_cmp_channel.sv
module sleep_cmp_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] count_next_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             clr_i,
    output logic             flag_o
);
    logic flag_d, flag_q;
    logic hit;

    always_comb begin
        hit    = step_i && (count_next_i == cmp_i);
        flag_d = (flag_q && !clr_i) || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer
    import sleep_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned PRE_W   = DEF_PRE_W,
    parameter int unsigned CODE_W  = DEF_CODE_W,
    parameter int unsigned MAXDIV  = DEF_MAXDIV,
    parameter int unsigned NCMP    = DEF_NCMP,
    parameter int unsigned WAKE_CH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast_i,
    input  logic              tick_slow_i,
    input  logic              src_sel_i,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic [CNT_W-1:0]  cmp_a_i,
    input  logic [CNT_W-1:0]  cmp_b_i,
    input  logic [NCMP-1:0]   irq_en_i,
    input  logic [NCMP-1:0]   flag_clr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [NCMP-1:0]   flag_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic             step;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] cmp_vec [NCMP];

    always_comb begin
        for (int i = 0; i < NCMP; i++) cmp_vec[i] = cmp_a_i;
        if (NCMP > 1) cmp_vec[NCMP-1] = cmp_b_i;
    end

    sleep_tick_prescaler #(.PRE_W(PRE_W), .CODE_W(CODE_W), .MAXDIV(MAXDIV)) u_presc (
        .clk(clk), .rst_n(rst_n),
        .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i),
        .src_sel_i(src_sel_i), .div_code_i(div_code_i),
        .step_o(step)
    );

    sleep_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(step),
        .count_q_o(count_q), .count_d_o(count_d)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        sleep_cmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .step_i(step),
            .count_next_i(count_d), .cmp_i(cmp_vec[g]),
            .clr_i(flag_clr_i[g]), .flag_o(flag_o[g])
        );
    end

    assign count_o = count_q;
    assign irq_o   = |(flag_o & irq_en_i);
    assign wake_o  = flag_o[WAKE_CH] & irq_en_i[WAKE_CH];
endmodule

// File: rtl/sleep_timer_checker.sv
module sleep_timer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_fast_i,
    input logic        tick_slow_i,
    input logic [15:0] cmp_a_i,
    input logic [1:0]  flag_clr_i,
    input logic [15:0] count_o,
    input logic [1:0]  flag_o,
    input logic        irq_o,
    input logic        wake_o
);
    assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> (count_o == 16'($past(count_o) + 16'd1)));

    assert_step_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> $past(tick_fast_i || tick_slow_i));

    assert_flag_a_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o[0]) |-> (count_o == $past(cmp_a_i)));

    assert_flag_a_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o[0]) |-> $past(flag_clr_i[0]));

    assert_flag_b_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o[1]) |-> $past(flag_clr_i[1]));

    assert_wake_from_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (flag_o[0] && irq_o));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o != 2'b00));
endmodule

bind sleep_wake_timer sleep_timer_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i),
    .cmp_a_i(cmp_a_i), .flag_clr_i(flag_clr_i),
    .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/sleep_wake_timer_test.sv
module sleep_wake_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_fast_i, tick_slow_i, src_sel_i;
    logic [3:0]  div_code_i;
    logic [15:0] cmp_a_i, cmp_b_i;
    logic [1:0]  irq_en_i, flag_clr_i;
    logic [15:0] count_o;
    logic [1:0]  flag_o;
    logic        irq_o, wake_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_pre, m_sel, m_code, m_flag;

    always #2.5 clk = ~clk;

    sleep_wake_timer uut (
        .clk(clk), .rst_n(rst_n),
        .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i),
        .src_sel_i(src_sel_i), .div_code_i(div_code_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
        .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
        .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_sel = 0; m_code = 0; m_flag = 0;
        end else begin
            int eff, period, tk, setv;
            bit inc;
            cycles++;
            eff    = (div_code_i > 10) ? 10 : int'(div_code_i);
            period = 1 << eff;
            tk     = src_sel_i ? tick_slow_i : tick_fast_i;
            inc    = 0;
            if (int'(src_sel_i) != m_sel || int'(div_code_i) != m_code) begin
                m_pre = 0;
            end else if (tk != 0) begin
                if ((m_pre % period) == period - 1) inc = 1;
                m_pre = (m_pre + 1) % 1024;
            end
            m_sel  = src_sel_i;
            m_code = div_code_i;
            setv   = 0;
            if (inc) begin
                m_cnt = (m_cnt + 1) % 65536;
                if (m_cnt == int'(cmp_a_i)) setv |= 1;
                if (m_cnt == int'(cmp_b_i)) setv |= 2;
            end
            m_flag = (m_flag & ~int'(flag_clr_i)) | setv;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int en;
        en = irq_en_i;
        check({tag, " count"}, count_o, m_cnt);
        check("R7 R8 flags", flag_o, m_flag);
        check("R9 wake", wake_o, ((m_flag & en & 1) != 0) ? 1 : 0);
        check("R10 irq", irq_o, ((m_flag & en) != 0) ? 1 : 0);
    endtask

    task automatic run(string tag, int n, bit sel, int code, int pf, int ps, int pclr);
        src_sel_i  = sel;
        div_code_i = 4'(code);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all(tag);
            tick_fast_i = (($urandom % 100) < pf);
            tick_slow_i = (($urandom % 100) < ps);
            flag_clr_i  = (($urandom % 100) < pclr) ? 2'($urandom % 4) : 2'b00;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        tick_fast_i = 0; tick_slow_i = 0; src_sel_i = 0; div_code_i = 0;
        cmp_a_i = 16'd100; cmp_b_i = 16'd300; irq_en_i = 2'b11; flag_clr_i = 0;
        repeat (3) @(negedge clk);
        check("R1 reset count", count_o, 0);
        check("R1 reset flags", flag_o, 0);
        check("R1 reset wake", wake_o, 0);
        check("R1 reset irq", irq_o, 0);
        rst_n = 1'b1;
        // R2: fast source, slow tick noise ignored
        run("R2", 400, 0, 0, 100, 50, 0);
        // R8: flags held, then cleared
        flag_clr_i = 2'b11;
        run("R8", 20, 0, 0, 0, 100, 0);
        // R2: slow source, fast tick noise ignored
        cmp_a_i = 16'd480; cmp_b_i = 16'd470;
        run("R2", 400, 1, 0, 100, 60, 3);
        // R3: several codes
        cmp_a_i = 16'd520; irq_en_i = 2'b10;
        run("R3", 1500, 0, 2, 90, 0, 2);
        run("R3", 1500, 1, 5, 0, 100, 2);
        run("R3", 1500, 0, 3, 100, 0, 2);
        // R4: clamp codes
        irq_en_i = 2'b01;
        run("R4", 3000, 0, 10, 100, 0, 1);
        run("R4", 3000, 0, 12, 100, 0, 1);
        run("R4", 3000, 1, 15, 0, 100, 1);
        // R6: frequent configuration changes
        for (int j = 0; j < 60; j++)
            run("R6", 7, 1'(j % 2), j % 4, 100, 100, 2);
        // R5: long run through the wrap
        cmp_a_i = 16'd3; cmp_b_i = 16'd65535; irq_en_i = 2'b11;
        run("R5", 70000, 0, 0, 100, 0, 1);
        check("R5 wrapped", (m_cnt < 10000) ? 1 : 0, 1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule